// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits on the private address window of a cluster of one to four cores. The window is 8 KiB. It holds a small snoop-control register set, and an address decoder that sends each bus access to one of five target kinds. The five targets are the snoop-control registers, the per-core interrupt CPU interfaces, the per-core timers, the per-core watchdogs and the shared interrupt distributor. For each accepted request the block registers a one-hot select, the index of the target core and the offset inside the selected window. It also registers read data for its own registers. All of these appear one cycle after the request.

Some windows are "current core" aliases. They use no fixed core index. An access to one of them is steered to the instance that belongs to the requesting core, as given by the core-ID input. Accesses that hit nothing all raise a decode-error flag and select no target. This covers windows for cores that are not present, holes in the map, and undefined or read-only-written register offsets.

Top module: `mcp_priv_decoder`

## Requirements
- R1: After synchronous reset, every output is zero and the control bit is clear, so a read of offset 0x000 returns 0.
- R2: A write to offset 0x000 stores only write-data bit 0. A later read of 0x000 returns that bit in bit 0, with bits 31:1 zero.
- R3: A read of offset 0x004 returns (core count − 1) in bits 3:0 and a mask with one set bit per present core starting at bit 4. For 3 cores this is 0x72.
- R4: Reads of offsets 0x008 and 0x00C return zero. A write to 0x00C is accepted without error and leaves the control bit unchanged.
- R5: Any other offset in 0x000–0x0FF, and any write to 0x004 or 0x008, raises the decode error, selects nothing, returns zero read data and leaves the control bit unchanged.
- R6: Select encoding is bit0 registers, bit1 CPU interface, bit2 timer, bit3 watchdog, bit4 distributor. An access at 0x200 + 0x100·c selects the CPU interface of core c, with local offset address[7:0].
- R7: Accesses in 0x100–0x1FF, and timer or watchdog accesses in 0x600–0x6FF, go to the instance numbered by the core-ID input.
- R8: Timer c sits at 0x700 + 0x100·c, offsets 0x00–0x1F. Watchdog c sits 0x20 above it, offsets 0x20–0x3F, with local offset address[7:0] − 0x20. Offsets 0x40–0xFF of these pages are decode errors.
- R9: Addresses 0x1000–0x1FFF select the distributor with local offset address[11:0] and core index 0, whatever the core-ID input.
- R10: A window for a core index at or above the core count, an alias access from such a core ID, and the unmapped range 0xB00–0xFFF all raise the decode error and select nothing.
- R11: Outputs reflect the request of the previous cycle. The select is one-hot or zero and never set together with the error. Write requests and idle cycles give zero read data, and idle cycles give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | Request is a write |
| req_addr | input | 13 | Byte offset inside the private window |
| req_wdata | input | DATA_W | Write data |
| req_core | input | 2 | ID of the requesting core |
| sel_o | output | 5 | One-hot target select (encoding in R6) |
| tgt_core_o | output | 2 | Core index of the selected instance |
| loc_off_o | output | 12 | Offset inside the selected window |
| dec_err_o | output | 1 | Decode error for the previous request |
| rd_data_o | output | DATA_W | Register read data for the previous request |

## Verification
The bench builds the block with three cores and 32-bit data. With that setting one core slot is always absent. The CPU-interface page at 0x500, the timer page at 0xA00 and alias accesses from core ID 3 must therefore all fail decoding, while cores 0–2 decode normally. The configuration value 0x72 tests both the count field and a mask that is not all ones. Requests are issued back to back, so each result must line up with the request exactly one cycle earlier.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int WIN_AW  = 13;
  localparam int OFF_W   = 12;
  localparam int CID_W   = 2;
  localparam int NUM_TGT = 5;

  typedef enum logic [2:0] {
    TGT_REGS  = 3'd0,
    TGT_CPUIF = 3'd1,
    TGT_TIMER = 3'd2,
    TGT_WDOG  = 3'd3,
    TGT_DIST  = 3'd4,
    TGT_NONE  = 3'd7
  } tgt_e;
endpackage

// File: rtl/mcp_addr_decode.sv
module mcp_addr_decode
  import mcp_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic              we,
  input  logic [CID_W-1:0]  core_id,
  output tgt_e              tgt,
  output logic [CID_W-1:0]  tgt_core,
  output logic [OFF_W-1:0]  loc_off,
  output logic              err
);
  localparam logic [2:0] NC3       = 3'(NUM_CORES);
  localparam logic [3:0] CPUIF_LO  = 4'd1;
  localparam logic [3:0] CPUIF_HI  = 4'd5;
  localparam logic [3:0] TMR_LO    = 4'd6;
  localparam logic [3:0] TMR_HI    = 4'd10;
  localparam logic [7:0] WDOG_BASE = 8'h20;
  localparam logic [7:0] WDOG_END  = 8'h40;

  logic [3:0] page;
  logic [7:0] low;
  logic [2:0] idx;

  assign page = addr[11:8];
  assign low  = addr[7:0];

  always_comb begin
    tgt      = TGT_NONE;
    tgt_core = '0;
    loc_off  = '0;
    err      = 1'b0;
    idx      = '0;
    if (addr[12]) begin
      tgt     = TGT_DIST;
      loc_off = addr[11:0];
    end else if (page == 4'd0) begin
      unique case (low)
        8'h00, 8'h0C: begin
          tgt     = TGT_REGS;
          loc_off = OFF_W'(low);
        end
        8'h04, 8'h08: begin
          if (we) err = 1'b1;
          else begin
            tgt     = TGT_REGS;
            loc_off = OFF_W'(low);
          end
        end
        default: err = 1'b1;
      endcase
    end else if (page >= CPUIF_LO && page <= CPUIF_HI) begin
      idx = (page == CPUIF_LO) ? 3'(core_id) : 3'(page - 4'd2);
      if (idx < NC3) begin
        tgt      = TGT_CPUIF;
        tgt_core = idx[CID_W-1:0];
        loc_off  = OFF_W'(low);
      end else begin
        err = 1'b1;
      end
    end else if (page >= TMR_LO && page <= TMR_HI) begin
      idx = (page == TMR_LO) ? 3'(core_id) : 3'(page - 4'd7);
      if (idx >= NC3 || low >= WDOG_END) begin
        err = 1'b1;
      end else if (low < WDOG_BASE) begin
        tgt      = TGT_TIMER;
        tgt_core = idx[CID_W-1:0];
        loc_off  = OFF_W'(low);
      end else begin
        tgt      = TGT_WDOG;
        tgt_core = idx[CID_W-1:0];
        loc_off  = OFF_W'(low - WDOG_BASE);
      end
    end else begin
      err = 1'b1;
    end
  end
endmodule

// File: rtl/mcp_scu_regs.sv
module mcp_scu_regs #(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              we,
  input  logic [7:0]        off,
  input  logic              wr_bit,
  output logic [DATA_W-1:0] rd_q
);
  localparam logic [DATA_W-1:0] CFG_VAL =
    DATA_W'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1));

  logic              ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (off)
      8'h00:   rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
      8'h04:   rd_mux = CFG_VAL;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (acc && we && off == 8'h00) ctrl_q <= wr_bit;
      rd_q <= (acc && !we) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mcp_priv_decoder.sv
module mcp_priv_decoder
  import mcp_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [WIN_AW-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [CID_W-1:0]   req_core,
  output logic [NUM_TGT-1:0] sel_o,
  output logic [CID_W-1:0]   tgt_core_o,
  output logic [OFF_W-1:0]   loc_off_o,
  output logic               dec_err_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  tgt_e               dec_tgt;
  logic [CID_W-1:0]   dec_core;
  logic [OFF_W-1:0]   dec_off;
  logic               dec_err;
  logic [NUM_TGT-1:0] sel_d;
  logic               hit;

  mcp_addr_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .addr     (req_addr),
    .we       (req_we),
    .core_id  (req_core),
    .tgt      (dec_tgt),
    .tgt_core (dec_core),
    .loc_off  (dec_off),
    .err      (dec_err)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
    assign sel_d[t] = req_valid && (dec_tgt == tgt_e'(t));
  end

  assign hit = |sel_d;

  mcp_scu_regs #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .acc    (sel_d[TGT_REGS]),
    .we     (req_we),
    .off    (dec_off[7:0]),
    .wr_bit (req_wdata[0]),
    .rd_q   (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o      <= '0;
      tgt_core_o <= '0;
      loc_off_o  <= '0;
      dec_err_o  <= 1'b0;
    end else begin
      sel_o      <= sel_d;
      tgt_core_o <= hit ? dec_core : '0;
      loc_off_o  <= hit ? dec_off : '0;
      dec_err_o  <= req_valid && dec_err;
    end
  end
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker
  import mcp_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [WIN_AW-1:0]  req_addr,
  input logic [CID_W-1:0]   req_core,
  input logic [NUM_TGT-1:0] sel_o,
  input logic [CID_W-1:0]   tgt_core_o,
  input logic [OFF_W-1:0]   loc_off_o,
  input logic               dec_err_o,
  input logic [DATA_W-1:0]  rd_data_o
);
  a_r11_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  a_r11_err_excl: assert property (@(posedge clk) disable iff (rst)
    dec_err_o |-> sel_o == '0);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (sel_o == '0 && !dec_err_o && rd_data_o == '0));

  a_r9_dist_sel: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[12]) |=> (sel_o == 5'b10000 && tgt_core_o == '0));

  a_r7_alias_core: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[12:8] == 5'h01 && 32'(req_core) < NUM_CORES)
      |=> (sel_o == 5'b00010 && tgt_core_o == $past(req_core)));

  a_r2_ctrl_width: assert property (@(posedge clk) disable iff (rst)
    (sel_o[0] && loc_off_o == '0) |-> rd_data_o[DATA_W-1:1] == '0);

  a_r8_wdog_off: assert property (@(posedge clk) disable iff (rst)
    (sel_o[2] || sel_o[3]) |-> loc_off_o < 12'h020);
endmodule

bind mcp_priv_decoder mcp_checker #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_core   (req_core),
  .sel_o      (sel_o),
  .tgt_core_o (tgt_core_o),
  .loc_off_o  (loc_off_o),
  .dec_err_o  (dec_err_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/tb_mcp_priv_decoder.sv
`timescale 1ns/1ps
module tb_mcp_priv_decoder;
  localparam int NC = 3;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [12:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_core = '0;
  logic [4:0]    sel_o;
  logic [1:0]    tgt_core_o;
  logic [11:0]   loc_off_o;
  logic          dec_err_o;
  logic [DW-1:0] rd_data_o;

  always #4 clk = ~clk;

  mcp_priv_decoder #(.NUM_CORES(NC), .DATA_W(DW)) dut (.*);

  typedef struct {
    logic [4:0]    sel;
    logic [1:0]    core;
    logic [11:0]   off;
    logic          err;
    logic [DW-1:0] rd;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic issued = 1'b0;
  bit   done = 1'b0;

  localparam logic [4:0] S_REG = 5'b00001, S_CIF = 5'b00010, S_TMR = 5'b00100,
                         S_WDG = 5'b01000, S_DST = 5'b10000, S_NO = 5'b00000;

  always @(posedge clk) issued <= rst ? 1'b0 : req_valid;

  // monitor: compare one cycle after each request
  always @(negedge clk) begin
    if (issued) begin
      exp_t e;
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected result sel=%b", sel_o);
      end else begin
        e = q.pop_front();
        if (sel_o !== e.sel || tgt_core_o !== e.core || loc_off_o !== e.off ||
            dec_err_o !== e.err || rd_data_o !== e.rd) begin
          n_bad++;
          $display("FAIL %s got sel=%b core=%0d off=%h err=%b rd=%h exp sel=%b core=%0d off=%h err=%b rd=%h",
                   e.tag, sel_o, tgt_core_o, loc_off_o, dec_err_o, rd_data_o,
                   e.sel, e.core, e.off, e.err, e.rd);
        end
      end
    end
  end

  task automatic acc(input logic we, input logic [12:0] a, input logic [DW-1:0] wd,
                     input logic [1:0] c, input logic [4:0] es, input logic [1:0] ec,
                     input logic [11:0] eo, input logic ee, input logic [DW-1:0] er,
                     input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_core = c;
    e.sel = es; e.core = ec; e.off = eo; e.err = ee; e.rd = er; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; req_addr = 13'h1FFF; req_core = 2'd3;
    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (sel_o !== '0 || dec_err_o !== 1'b0 || rd_data_o !== '0 ||
        tgt_core_o !== '0 || loc_off_o !== '0) begin
      n_bad++;
      $display("FAIL %s idle got sel=%b err=%b rd=%h exp all zero",
               tag, sel_o, dec_err_o, rd_data_o);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_cmp++; // R1 reset state
    if (sel_o !== '0 || dec_err_o !== 1'b0 || rd_data_o !== '0 ||
        tgt_core_o !== '0 || loc_off_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs sel=%b err=%b rd=%h exp zero", sel_o, dec_err_o, rd_data_o);
    end
    // R1 / R3 / R2 / R4
    acc(0, 13'h000, '0, 0, S_REG, 0, 12'h000, 0, 32'h0, "R1 ctrl after reset");
    acc(0, 13'h004, '0, 1, S_REG, 0, 12'h004, 0, 32'h72, "R3 config");
    acc(1, 13'h000, 32'hFFFF_FFFF, 0, S_REG, 0, 12'h000, 0, 32'h0, "R2 write ctrl");
    acc(0, 13'h000, '0, 0, S_REG, 0, 12'h000, 0, 32'h1, "R2 ctrl readback");
    acc(1, 13'h00C, 32'h0, 2, S_REG, 0, 12'h00C, 0, 32'h0, "R4 invalidate write");
    acc(0, 13'h000, '0, 0, S_REG, 0, 12'h000, 0, 32'h1, "R4 ctrl unchanged");
    acc(0, 13'h008, '0, 0, S_REG, 0, 12'h008, 0, 32'h0, "R4 status read");
    acc(0, 13'h00C, '0, 0, S_REG, 0, 12'h00C, 0, 32'h0, "R4 invalidate read");
    // R5 bad offsets
    acc(0, 13'h010, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R5 undefined read");
    acc(1, 13'h004, 32'h0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R5 write config");
    acc(1, 13'h008, 32'h0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R5 write status");
    acc(1, 13'h0F0, 32'h0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R5 undefined write");
    acc(0, 13'h000, '0, 0, S_REG, 0, 12'h000, 0, 32'h1, "R5 ctrl unchanged");
    acc(1, 13'h000, 32'hFFFF_FFFE, 0, S_REG, 0, 12'h000, 0, 32'h0, "R2 clear ctrl");
    acc(0, 13'h000, '0, 0, S_REG, 0, 12'h000, 0, 32'h0, "R2 ctrl cleared");
    // R6 CPU interface
    acc(0, 13'h234, '0, 2, S_CIF, 0, 12'h034, 0, 32'h0, "R6 cpuif core0");
    acc(1, 13'h3FC, 32'h5, 0, S_CIF, 1, 12'h0FC, 0, 32'h0, "R6 cpuif core1");
    acc(0, 13'h400, '0, 0, S_CIF, 2, 12'h000, 0, 32'h0, "R6 cpuif core2");
    // R7 alias
    acc(0, 13'h180, '0, 2, S_CIF, 2, 12'h080, 0, 32'h0, "R7 cpuif alias");
    acc(0, 13'h610, '0, 1, S_TMR, 1, 12'h010, 0, 32'h0, "R7 timer alias");
    acc(1, 13'h624, 32'h1, 2, S_WDG, 2, 12'h004, 0, 32'h0, "R7 wdog alias");
    // R8 timers and watchdogs
    acc(0, 13'h71F, '0, 2, S_TMR, 0, 12'h01F, 0, 32'h0, "R8 timer core0 top");
    acc(0, 13'h920, '0, 0, S_WDG, 2, 12'h000, 0, 32'h0, "R8 wdog core2 base");
    acc(0, 13'h83F, '0, 0, S_WDG, 1, 12'h01F, 0, 32'h0, "R8 wdog core1 top");
    acc(0, 13'h840, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R8 past wdog");
    // R9 distributor
    acc(0, 13'h1000, '0, 1, S_DST, 0, 12'h000, 0, 32'h0, "R9 dist base");
    acc(1, 13'h1FFC, 32'h3, 2, S_DST, 0, 12'hFFC, 0, 32'h0, "R9 dist top");
    // R10 absent core and holes
    acc(0, 13'h500, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R10 cpuif absent");
    acc(0, 13'hA00, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R10 timer absent");
    acc(0, 13'h1C0, '0, 3, S_NO, 0, 12'h000, 1, 32'h0, "R10 alias absent core");
    acc(0, 13'h630, '0, 3, S_NO, 0, 12'h000, 1, 32'h0, "R10 wdog alias absent core");
    acc(0, 13'hB10, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R10 hole B00");
    acc(0, 13'hFFF, '0, 0, S_NO, 0, 12'h000, 1, 32'h0, "R10 hole FFF");
    // R11 idle
    idle_check("R11");
    acc(0, 13'h004, '0, 0, S_REG, 0, 12'h004, 0, 32'h72, "R11 after idle");
    idle_check("R11 second");
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 %0d results missing", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule